// File: doc/BRIEF.md
# Flash Converter Output Encoder

This block sits behind the comparator bank of an 8-bit flash analog-to-digital converter. It receives the 255 code comparator decisions as a thermometer vector, plus a separate comparator that trips only above the highest code threshold. On every rising edge of the sample clock it produces a registered binary code together with an overrange flag. Isolated comparator disagreements ("bubbles") are removed before the vector is turned into a number.

Two polarity controls reshape the code for downstream logic. One flips only the most significant bit, which gives offset binary or two's complement style output. The other flips only the seven lower bits. Both the code and the overrange flag are driven in true and complemented form. The overrange pair never follows the polarity controls.

Top module: `flash_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces `code_out` to 0x00, `code_out_n` to 0xFF, `over_n` to 1 and `over_p` to 0, whatever the other inputs are.
- R2: With `over_cmp` low, both polarity controls low and a clean thermometer whose k lowest bits are 1 (bit 0 is the lowest threshold), `code_out` equals k for every k from 0 to 255.
- R3: Each comparator bit is replaced by the 2-of-3 majority of itself and its two neighbours before encoding. Below bit 0 the neighbour is taken as 1. Above bit 254 the neighbour is `over_cmp`. So a single flipped bit inside a thermometer does not change the code.
- R4: When `over_cmp` is 1, the code before polarity inversion is 255, regardless of the thermometer bits.
- R5: `inv_top` high inverts bit 7 of `code_out` and leaves bits 6..0 unchanged.
- R6: `inv_low` high inverts bits 6..0 of `code_out` and leaves bit 7 unchanged.
- R7: `over_n` is 0 and `over_p` is 1 exactly when `over_cmp` was 1 at the sampling edge. Neither polarity control affects them.
- R8: In every cycle, `code_out_n` is the bitwise inverse of `code_out` and `over_n` is the inverse of `over_p`.
- R9: The outputs after a rising edge reflect only the inputs sampled at that edge (one cycle of latency). Unchanged inputs give unchanged outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| therm_in | input | 255 | Code comparator outputs, bit i set when the input is above threshold i |
| over_cmp | input | 1 | Overrange comparator, set above the top code threshold |
| inv_top | input | 1 | Polarity control for bit 7 of the code |
| inv_low | input | 1 | Polarity control for bits 6..0 of the code |
| code_out | output | 8 | Registered output code |
| code_out_n | output | 8 | Bitwise complement of `code_out` |
| over_n | output | 1 | Overrange flag, low while over range |
| over_p | output | 1 | Overrange flag, high while over range |

## Verification
The hardest situations to reach are bubbles at the two ends of the comparator vector. There, the vote relies on an implied neighbour below bit 0 and on the overrange comparator above bit 254. The stimulus builds these directly: a lone set bit 1 above a cleared bit 0, and a cleared bit 253 under a set bit 254 with `over_cmp` low. A scoreboard predicts the code for each case from the majority rule applied bit by bit. Overrange is also driven with scrambled thermometer contents under all four polarity settings. This shows that saturation happens before inversion and that the overrange pair ignores polarity.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

  // 2-of-3 vote used by the bubble filter
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  typedef struct packed {
    logic top;
    logic low;
  } polarity_t;

endpackage

// File: rtl/flash_bubble_vote.sv
module flash_bubble_vote
  import flash_enc_pkg::*;
#(
  parameter int N = 255
) (
  input  logic [N-1:0] therm,
  input  logic         top_bit,
  output logic [N-1:0] clean
);

  for (genvar i = 0; i < N; i++) begin : g_vote
    logic below;
    logic above;
    if (i == 0) begin : g_bot
      assign below = 1'b1;
    end else begin : g_mid_lo
      assign below = therm[i-1];
    end
    if (i == N - 1) begin : g_top
      assign above = top_bit;
    end else begin : g_mid_hi
      assign above = therm[i+1];
    end
    assign clean[i] = maj3(below, therm[i], above);
  end

endmodule

// File: rtl/flash_ones_encoder.sv
module flash_ones_encoder #(
  parameter int N = 255,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] count
);

  function automatic logic [W-1:0] ones_of(input logic [N-1:0] v);
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = acc + {{(W-1){1'b0}}, v[i]};
    end
    return acc;
  endfunction

  assign count = ones_of(vec);

endmodule

// File: rtl/flash_out_stage.sv
module flash_out_stage
  import flash_enc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] count,
  input  logic         sat,
  input  polarity_t    pol,
  output logic [W-1:0] code_q,
  output logic [W-1:0] code_nq,
  output logic         ovr_nq,
  output logic         ovr_pq
);

  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] code_pre;
  logic [W-1:0] pol_mask;
  logic [W-1:0] code_next;

  assign code_pre  = sat ? FULL : count;
  assign pol_mask  = {pol.top, {(W-1){pol.low}}};
  assign code_next = code_pre ^ pol_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      code_nq <= FULL;
      ovr_nq  <= 1'b1;
      ovr_pq  <= 1'b0;
    end else begin
      code_q  <= code_next;
      code_nq <= ~code_next;
      ovr_nq  <= ~sat;
      ovr_pq  <= sat;
    end
  end

  // R8
  code_cmpl_chk: assert property (@(posedge clk) disable iff (rst)
    code_nq == ~code_q);

  // R8
  over_cmpl_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_nq == ~ovr_pq);

endmodule

// File: rtl/flash_encoder.sv
module flash_encoder
  import flash_enc_pkg::*;
#(
  parameter int RES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(2**RES)-2:0]   therm_in,
  input  logic                  over_cmp,
  input  logic                  inv_top,
  input  logic                  inv_low,
  output logic [RES-1:0]        code_out,
  output logic [RES-1:0]        code_out_n,
  output logic                  over_n,
  output logic                  over_p
);

  localparam int THERM_W = (2**RES) - 1;
  localparam int CNT_W   = $clog2(THERM_W + 1);

  logic [THERM_W-1:0] voted;
  logic [CNT_W-1:0]   ones;
  polarity_t          pol;

  assign pol.top = inv_top;
  assign pol.low = inv_low;

  flash_bubble_vote #(.N(THERM_W)) u_vote (
    .therm   (therm_in),
    .top_bit (over_cmp),
    .clean   (voted)
  );

  flash_ones_encoder #(.N(THERM_W), .W(CNT_W)) u_count (
    .vec   (voted),
    .count (ones)
  );

  flash_out_stage #(.W(RES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .count   (ones),
    .sat     (over_cmp),
    .pol     (pol),
    .code_q  (code_out),
    .code_nq (code_out_n),
    .ovr_nq  (over_n),
    .ovr_pq  (over_p)
  );

  // R4
  sat_code_chk: assert property (@(posedge clk) disable iff (rst)
    over_cmp |=> ((code_out ^ {$past(inv_top), {(RES-1){$past(inv_low)}}}) == {RES{1'b1}}));

  // R7
  over_set_chk: assert property (@(posedge clk) disable iff (rst)
    over_cmp |=> (over_p && !over_n));

  // R7
  over_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !over_cmp |=> (!over_p && over_n));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(therm_in) && $stable(over_cmp) && $stable(inv_top) &&
     $stable(inv_low) && !$past(rst)) |=> $stable(code_out));

endmodule

// File: tb/flash_encoder_bench.sv
module flash_encoder_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [254:0] therm_in = '0;
  logic         over_cmp = 1'b0;
  logic         inv_top = 1'b0;
  logic         inv_low = 1'b0;
  logic [7:0]   code_out, code_out_n;
  logic         over_n, over_p;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_code_q[$];
  logic       exp_ovr_q[$];
  string      exp_tag_q[$];

  always #4 clk = ~clk;

  flash_encoder u_flash_encoder (
    .clk        (clk),
    .rst        (rst),
    .therm_in   (therm_in),
    .over_cmp   (over_cmp),
    .inv_top    (inv_top),
    .inv_low    (inv_low),
    .code_out   (code_out),
    .code_out_n (code_out_n),
    .over_n     (over_n),
    .over_p     (over_p)
  );

  function automatic logic [254:0] thermo(input int k);
    logic [254:0] t = '0;
    for (int i = 0; i < k; i++) t[i] = 1'b1;
    return t;
  endfunction

  // Independent model: count-based vote, then saturate, then polarity
  function automatic logic [7:0] model(input logic [254:0] t, input logic o,
                                       input logic it, input logic il);
    int n = 0;
    logic [7:0] c;
    for (int i = 0; i < 255; i++) begin
      int lo, hi, votes;
      lo = (i == 0) ? 1 : int'(t[i-1]);
      hi = (i == 254) ? int'(o) : int'(t[i+1]);
      votes = lo + int'(t[i]) + hi;
      if (votes >= 2) n++;
    end
    if (o) n = 255;
    c = n[7:0];
    c[7] = c[7] ^ it;
    c[6:0] = c[6:0] ^ {7{il}};
    return c;
  endfunction

  task automatic drive(input logic [254:0] t, input logic o, input logic it,
                       input logic il, input string tag);
    @(negedge clk);
    therm_in = t; over_cmp = o; inv_top = it; inv_low = il;
    exp_code_q.push_back(model(t, o, it, il));
    exp_ovr_q.push_back(o);
    exp_tag_q.push_back(tag);
  endtask

  task automatic check_reset(input string tag);
    @(negedge clk);
    therm_in = '1; over_cmp = 1'b1; inv_top = 1'b1; inv_low = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (code_out !== 8'h00 || code_out_n !== 8'hFF || over_n !== 1'b1 || over_p !== 1'b0) begin
      fails++;
      $display("FAIL %s reset: got code=%h n=%h over_n=%b over_p=%b exp 00 ff 1 0",
               tag, code_out, code_out_n, over_n, over_p);
    end
    rst = 1'b0;
  endtask

  // Scoreboard monitor: sample 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_code_q.size() > 0) begin
      logic [7:0] ec;
      logic eo;
      string tg;
      ec = exp_code_q.pop_front();
      eo = exp_ovr_q.pop_front();
      tg = exp_tag_q.pop_front();
      checks++;
      if (code_out !== ec) begin
        fails++;
        $display("FAIL %s code: got %h exp %h", tg, code_out, ec);
      end
      // R8 complements, R7 overrange pair
      if (code_out_n !== ~ec || over_p !== eo || over_n !== ~eo) begin
        fails++;
        $display("FAIL %s/R7/R8 flags: got n=%h p=%b on=%b exp n=%h p=%b on=%b",
                 tg, code_out_n, over_p, over_n, ~ec, eo, ~eo);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [254:0] t;
    // R1 reset from time zero
    check_reset("R1");

    // R2 clean thermometer sweep, R9 one-cycle latency per sample
    for (int k = 0; k <= 255; k++) drive(thermo(k), 1'b0, 1'b0, 1'b0, "R2");
    drive(thermo(77), 1'b0, 1'b0, 1'b0, "R9");
    drive(thermo(77), 1'b0, 1'b0, 1'b0, "R9");
    drive(thermo(3), 1'b0, 1'b0, 1'b0, "R9");

    // R3 bubbles in the middle and at both ends
    t = thermo(100); t[98] = 1'b0;
    drive(t, 1'b0, 1'b0, 1'b0, "R3");
    t = thermo(100); t[105] = 1'b1;
    drive(t, 1'b0, 1'b0, 1'b0, "R3");
    t = '0; t[1] = 1'b1;
    drive(t, 1'b0, 1'b0, 1'b0, "R3");
    t = '1; t[253] = 1'b0;
    drive(t, 1'b0, 1'b0, 1'b0, "R3");
    t = thermo(254); t[254] = 1'b0;
    drive(t, 1'b1, 1'b0, 1'b0, "R3");

    // R4 saturation on overrange with scrambled vectors
    drive('0, 1'b1, 1'b0, 1'b0, "R4");
    drive(thermo(40), 1'b1, 1'b0, 1'b0, "R4");

    // R5 / R6 polarity controls
    for (int k = 0; k < 256; k += 37) begin
      drive(thermo(k), 1'b0, 1'b1, 1'b0, "R5");
      drive(thermo(k), 1'b0, 1'b0, 1'b1, "R6");
      drive(thermo(k), 1'b0, 1'b1, 1'b1, "R6");
    end
    drive(thermo(128), 1'b0, 1'b1, 1'b0, "R5");
    drive(thermo(127), 1'b0, 1'b0, 1'b1, "R6");

    // R7 overrange pair ignores polarity
    drive(thermo(200), 1'b1, 1'b1, 1'b0, "R7");
    drive(thermo(10),  1'b1, 1'b0, 1'b1, "R7");
    drive('1,          1'b1, 1'b1, 1'b1, "R7");
    drive('1,          1'b0, 1'b1, 1'b1, "R7");

    // R1 mid-run reset with active inputs
    check_reset("R1");
    drive(thermo(5), 1'b0, 1'b0, 1'b0, "R9");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule